// File: doc/BRIEF.md
# Receive Error Tally with Timed and Manual Reporting

This block counts receive-line error strobes produced by a separate detector and hands the running total to a host through byte-wide holding registers. A two-bit selector picks which strobe feeds the counter: line violations, excess-zero events, pattern errors, or violations and excess zeros together. When both of the combined strobes fire in one cycle, the count rises by two.

The total is moved from the counter into the holding registers in one of two ways. In timed mode, an internal period timer of `PERIOD_CYC` clocks triggers the move. In manual mode, the host sets a trigger bit, and the move happens on its rising edge. The move clears the counter in the same cycle. A strobe that arrives in that cycle becomes the first count of the new period, so no error is lost. The count stops at the counter's all-ones value instead of wrapping, and an overflow flag is raised.

Three sticky status flags record an error, an overflow and a timer expiry. A read of the status address clears them. Each flag has a mask, and the interrupt output is the OR of the unmasked flags.

Top module: `rx_err_tally`

## Requirements
- R1: After reset, the control register (address 0) reads 0, which selects manual mode and selector 00. The mask register (address 1) reads 0x07, the status register (address 2) reads 0, both holding bytes (address 3 low, address 4 high) read 0, and `irq` is 0.
- R2: Control bits [1:0] select the counted strobe: 00 counts `viol_stb`, 01 counts `exz_stb`, 10 counts `pat_stb`, 11 counts `viol_stb` plus `exz_stb`. Strobes that are not selected leave the count unchanged.
- R3: With selector 11, a cycle in which `viol_stb` and `exz_stb` are both high adds 2 to the count.
- R4: In manual mode (control bit 2 = 0), a write that takes control bit 3 from 0 to 1 copies the count into the holding bytes on the next clock and clears the counter. A write that leaves bit 3 at 1 transfers nothing.
- R5: A selected strobe in the same cycle as a transfer is not added to the total being reported. It becomes the first count of the new period.
- R6: In timed mode (control bit 2 = 1), the period timer restarts from zero when the mode is entered. A transfer happens every `PERIOD_CYC` clocks, the first one `PERIOD_CYC` clocks after the write edge that entered the mode. Each timed transfer sets status bit 2.
- R7: The count saturates at 2^CNT_W-1 until the next transfer. An increment that would pass that value sets status bit 1.
- R8: Every cycle with a counted strobe sets status bit 0.
- R9: A read of address 2 returns the status flags and clears them, except that a flag set by an event in the same cycle as the read stays set.
- R10: `irq` is high exactly when some status bit is 1 and its mask bit (same position in address 1, 1 = masked) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_stb | input | 1 | Line violation strobe, one cycle per error |
| exz_stb | input | 1 | Excess-zero strobe |
| pat_stb | input | 1 | Pattern error strobe |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable (a status read clears flags) |
| addr | input | AW (3) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt, OR of unmasked status flags |

## Verification
A strobe is counted on the clock edge it is presented at. A manual transfer lands one clock after the trigger-setting write. A timed transfer and its status flag land `PERIOD_CYC` clocks after the mode-entering write. `rdata` and `irq` reflect state in the same cycle. The bench drives inputs on falling edges, counts each rising edge between stimulus and check, and reads results only after the edge on which they are due. It samples `irq` in the cycle just before a timed expiry as well as just after it, so a transfer that comes one cycle early or late is caught.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

  typedef enum logic [1:0] {
    SEL_VIOL     = 2'b00,
    SEL_EXZ      = 2'b01,
    SEL_PAT      = 2'b10,
    SEL_VIOL_EXZ = 2'b11
  } err_sel_e;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_MASK  = 1;
  localparam int A_STAT  = 2;
  localparam int A_HOLD0 = 3;

  // control bit positions
  localparam int C_AUTO = 2;
  localparam int C_TRIG = 3;

  // status / mask bit positions
  localparam int B_ERR = 0;
  localparam int B_OVF = 1;
  localparam int B_TMR = 2;
  localparam int NFLAG = 3;

  // number of counts contributed by the strobes in one cycle
  function automatic logic [1:0] sel_inc(input err_sel_e sel,
                                         input logic v, input logic e,
                                         input logic p);
    logic [1:0] r;
    case (sel)
      SEL_VIOL:     r = {1'b0, v};
      SEL_EXZ:      r = {1'b0, e};
      SEL_PAT:      r = {1'b0, p};
      SEL_VIOL_EXZ: r = {1'b0, v} + {1'b0, e};
      default:      r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rx_err_select.sv
module rx_err_select
  import rx_err_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       viol,
  input  logic       exz,
  input  logic       pat,
  output logic [1:0] inc,
  output logic       err_evt
);

  always_comb begin
    inc     = sel_inc(err_sel_e'(sel), viol, exz, pat);
    err_evt = (inc != 2'd0);
  end

endmodule

// File: rtl/rx_err_timer.sv
module rx_err_timer #(
  parameter int PERIOD_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int TW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

  logic [TW-1:0] tmr_q;

  // held at zero while stopped, so entering timed mode starts a full period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmr_q <= '0;
    else if (!run)         tmr_q <= '0;
    else if (tmr_q == LAST) tmr_q <= '0;
    else                   tmr_q <= tmr_q + 1'b1;
  end

  assign tick = run && (tmr_q == LAST);

endmodule

// File: rtl/rx_err_accum.sv
module rx_err_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  input  logic             xfer,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hold,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, hold_q;
  logic [CNT_W:0]   step;

  // returns {overflow, saturated next count}
  function automatic logic [CNT_W:0] sat_step(input logic [CNT_W-1:0] c,
                                              input logic [1:0] d);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W+1)'(d);
    if (s[CNT_W]) return {1'b1, CMAX};
    return s;
  endfunction

  assign step    = sat_step(cnt_q, inc);
  assign ovf_evt = !xfer && step[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (xfer) begin
      hold_q <= cnt_q;
      cnt_q  <= CNT_W'(inc);   // strobes of the transfer cycle open the new period
    end else begin
      cnt_q  <= step[CNT_W-1:0];
    end
  end

  assign cnt  = cnt_q;
  assign hold = hold_q;

endmodule

// File: rtl/rx_err_regs.sv
module rx_err_regs
  import rx_err_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [CNT_W-1:0] hold,
  input  logic             err_evt,
  input  logic             ovf_evt,
  input  logic             tick_evt,
  output logic [1:0]       sel,
  output logic             auto_mode,
  output logic             man_evt,
  output logic [NFLAG-1:0] stat,
  output logic [NFLAG-1:0] mask,
  output logic             irq
);

  localparam int NB = (CNT_W + 7) / 8;

  logic [1:0]       sel_q;
  logic             auto_q, trig_q, trig_prev_q;
  logic [NFLAG-1:0] mask_q, stat_q, stat_set, stat_next;
  logic             wr_ctrl, wr_mask, rd_clr;
  logic [NB*8-1:0]  hold_pad;
  logic [3:0]       wdata_unused;

  assign wdata_unused = wdata[7:4];
  assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
  assign wr_mask = wr_en && (addr == AW'(A_MASK));
  assign rd_clr  = rd_en && (addr == AW'(A_STAT));

  always_comb begin
    stat_set        = '0;
    stat_set[B_ERR] = err_evt;
    stat_set[B_OVF] = ovf_evt;
    stat_set[B_TMR] = tick_evt;
    stat_next       = (rd_clr ? '0 : stat_q) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      auto_q      <= 1'b0;
      trig_q      <= 1'b0;
      trig_prev_q <= 1'b0;
      mask_q      <= '1;
      stat_q      <= '0;
    end else begin
      trig_prev_q <= trig_q;
      stat_q      <= stat_next;
      if (wr_ctrl) begin
        sel_q  <= wdata[1:0];
        auto_q <= wdata[C_AUTO];
        trig_q <= wdata[C_TRIG];
      end
      if (wr_mask) mask_q <= wdata[NFLAG-1:0];
    end
  end

  assign man_evt   = trig_q && !trig_prev_q;
  assign sel       = sel_q;
  assign auto_mode = auto_q;
  assign stat      = stat_q;
  assign mask      = mask_q;
  assign irq       = |(stat_q & ~mask_q);
  assign hold_pad  = (NB*8)'(hold);

  always_comb begin
    rdata = 8'h00;
    if (addr == AW'(A_CTRL)) rdata = {4'b0, trig_q, auto_q, sel_q};
    if (addr == AW'(A_MASK)) rdata = 8'(mask_q);
    if (addr == AW'(A_STAT)) rdata = 8'(stat_q);
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(A_HOLD0 + b)) rdata = hold_pad[b*8 +: 8];
    end
  end

endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally
  import rx_err_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PERIOD_CYC = 1000000,
  parameter int AW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol_stb,
  input  logic          exz_stb,
  input  logic          pat_stb,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);

  // named internal events
  logic [1:0]       sel;
  logic             auto_mode;
  logic [1:0]       inc;
  logic             err_evt, ovf_evt, tick_evt, man_evt, xfer_evt;
  logic [CNT_W-1:0] cnt, hold;
  logic [NFLAG-1:0] stat, mask;

  rx_err_select u_sel (
    .sel     (sel),
    .viol    (viol_stb),
    .exz     (exz_stb),
    .pat     (pat_stb),
    .inc     (inc),
    .err_evt (err_evt)
  );

  rx_err_timer #(.PERIOD_CYC(PERIOD_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (auto_mode),
    .tick  (tick_evt)
  );

  assign xfer_evt = tick_evt || (man_evt && !auto_mode);

  rx_err_accum #(.CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .xfer    (xfer_evt),
    .cnt     (cnt),
    .hold    (hold),
    .ovf_evt (ovf_evt)
  );

  rx_err_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .hold      (hold),
    .err_evt   (err_evt),
    .ovf_evt   (ovf_evt),
    .tick_evt  (tick_evt),
    .sel       (sel),
    .auto_mode (auto_mode),
    .man_evt   (man_evt),
    .stat      (stat),
    .mask      (mask),
    .irq       (irq)
  );

endmodule

// File: rtl/rx_err_tally_chk.sv
module rx_err_tally_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             viol_stb,
  input logic [1:0]       sel,
  input logic             auto_mode,
  input logic [1:0]       inc,
  input logic             err_evt,
  input logic             ovf_evt,
  input logic             tick_evt,
  input logic             xfer_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold,
  input logic [2:0]       stat
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && !viol_stb) |-> (inc == 2'd0));

  a_r3_add_two: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_evt && inc == 2'd2 && cnt < CMAX - 1) |=> (cnt == $past(cnt) + 2));

  a_r4_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> (hold == $past(cnt)));

  a_r5_carry_next: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> (cnt == CNT_W'($past(inc))));

  a_r6_manual_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> !tick_evt);

  a_r6_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> stat[2]);

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !xfer_evt) |=> (cnt == CMAX));

  a_r7_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat[1]);

  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stat[0]);

endmodule

bind rx_err_tally rx_err_tally_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .viol_stb  (viol_stb),
  .sel       (sel),
  .auto_mode (auto_mode),
  .inc       (inc),
  .err_evt   (err_evt),
  .ovf_evt   (ovf_evt),
  .tick_evt  (tick_evt),
  .xfer_evt  (xfer_evt),
  .cnt       (cnt),
  .hold      (hold),
  .stat      (stat)
);

// File: tb/rx_err_tally_tb.sv
module rx_err_tally_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PERIOD     = 40;
  localparam int AW         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          viol_stb = 1'b0, exz_stb = 1'b0, pat_stb = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [1:0] cur_sel = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_tally #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .viol_stb(viol_stb), .exz_stb(exz_stb),
    .pat_stb(pat_stb), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input int a, input int d);
    wr_en = 1'b1; addr = AW'(a); wdata = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    rd_en = 1'b1; addr = AW'(a);
    #1 d = int'(rdata);
    step();
    rd_en = 1'b0;
  endtask

  task automatic rd_hold(output int h);
    int lo, hi;
    reg_rd(3, lo);
    reg_rd(4, hi);
    h = (hi << 8) | lo;
  endtask

  // manual transfer: set trigger bit, then clear it (transfer on the second edge)
  task automatic trigger();
    reg_wr(0, 8 | int'(cur_sel));
    reg_wr(0, int'(cur_sel));
  endtask

  task automatic strobe(input bit v, input bit e, input bit p);
    viol_stb = v; exz_stb = e; pat_stb = p;
    step();
    viol_stb = 1'b0; exz_stb = 1'b0; pat_stb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d, h, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    reg_rd(0, d); check("R1 ctrl", d, 0);
    reg_rd(1, d); check("R1 mask", d, 7);
    reg_rd(2, d); check("R1 stat", d, 0);
    rd_hold(h);   check("R1 hold", h, 0);

    // R2/R3/R8 sweep over selector and strobe phase
    for (int s = 0; s < 4; s++) begin
      cur_sel = 2'(s);
      reg_wr(0, s);
      for (int ph = 0; ph < 3; ph++) begin
        trigger();
        reg_rd(2, d);
        exp = 0;
        for (int i = 0; i < 30; i++) begin
          bit v, e, p;
          v = ((i + ph) % 2) == 0;
          e = ((i + ph) % 3) == 0;
          p = ((i + ph) % 5) == 0;
          case (s)
            0: exp += int'(v);
            1: exp += int'(e);
            2: exp += int'(p);
            default: exp += int'(v) + int'(e);
          endcase
          strobe(v, e, p);
        end
        trigger();
        rd_hold(h);
        if (s == 3) check("R3 combined count", h, exp);
        else        check("R2 selected count", h, exp);
        reg_rd(2, d);
        check("R8 error flag", d & 1, (exp > 0) ? 1 : 0);
      end
    end

    // R4 trigger held at 1 does not transfer again
    cur_sel = 2'b00;
    reg_wr(0, 0);
    trigger();
    reg_wr(0, 8);
    repeat (4) strobe(1, 0, 0);
    reg_wr(0, 8);
    step();
    rd_hold(h); check("R4 no re-trigger", h, 0);
    reg_wr(0, 0);
    reg_wr(0, 8);
    step();
    rd_hold(h); check("R4 rising edge transfers", h, 4);
    reg_wr(0, 0);

    // R5 strobe in transfer cycle joins the next period
    repeat (2) strobe(1, 0, 0);
    reg_wr(0, 8);
    strobe(1, 0, 0);           // this edge performs the transfer
    reg_wr(0, 0);
    rd_hold(h); check("R5 reported total", h, 2);
    trigger();
    rd_hold(h); check("R5 carried strobe", h, 1);

    // R9 event during clearing read is kept
    reg_rd(2, d);
    viol_stb = 1'b1; rd_en = 1'b1; addr = 3'd2;
    #1 d = int'(rdata);
    step();
    viol_stb = 1'b0; rd_en = 1'b0;
    check("R9 read before event", d, 0);
    reg_rd(2, d); check("R9 coincident event kept", d, 1);
    reg_rd(2, d); check("R9 cleared on read", d, 0);

    // R10 interrupt masking
    reg_wr(1, 6);
    check("R10 idle irq", int'(irq), 0);
    strobe(1, 0, 0);
    check("R10 unmasked error", int'(irq), 1);
    reg_wr(1, 7);
    check("R10 masked error", int'(irq), 0);
    reg_wr(1, 6);
    check("R10 unmask again", int'(irq), 1);
    reg_rd(2, d);
    check("R10 cleared", int'(irq), 0);

    // R6 timed mode
    trigger();
    reg_wr(1, 3);
    reg_rd(2, d);
    reg_wr(0, 4);              // edge E
    repeat (10) strobe(1, 0, 0);
    repeat (PERIOD - 11) step();
    check("R6 no early expiry", int'(irq), 0);
    step();
    check("R6 expiry at period", int'(irq), 1);
    reg_rd(3, d); check("R6 timed hold", d, 10);
    reg_rd(2, d); check("R6 timer flag", d & 4, 4);
    repeat (PERIOD - 2) step();
    check("R6 second expiry", int'(irq), 1);
    rd_hold(h); check("R6 empty period", h, 0);
    reg_wr(0, 0);
    reg_rd(2, d);
    reg_wr(1, 7);

    // R7 saturation and overflow flag
    cur_sel = 2'b11;
    reg_wr(0, 3);
    trigger();
    reg_rd(2, d);
    repeat (32767) strobe(1, 1, 0);
    reg_rd(2, d); check("R7 no overflow below max", d & 2, 0);
    repeat (6) strobe(1, 1, 0);
    reg_rd(2, d); check("R7 overflow flag", d & 2, 2);
    trigger();
    rd_hold(h); check("R7 saturated total", h, 65535);
    repeat (3) strobe(1, 0, 0);
    trigger();
    rd_hold(h); check("R7 restart after transfer", h, 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule